// File: doc/BRIEF.md
# Tearing-Effect Frame Start Trigger

This block decides when a frame transfer to a command-mode panel may begin. It watches the panel's tearing-effect line, which carries both line (hsync) and frame (vsync) pulses. It tells the two apart only by how long each pulse lasts. Once a transfer has been requested, it raises a one-cycle start pulse towards the pixel packer at one of three moments:

- straight away, when the internal trigger is selected;
- on the first vsync that follows the request;
- on a chosen line, counted in hsyncs from the last vsync.

The pulse widths, the active level of each pulse kind, the trigger mode and the target line are all set by quasi-static configuration inputs. A request arms the block. After the start pulse, the block stays locked until the frame-done input shows that the transfer has finished, and only then can it be armed again. If the width settings do not allow hsync and vsync to be told apart safely, the configuration is flagged as invalid and requests are refused. Every port is a plain level or pulse, and no port has back-pressure.

Top module: `te_sync_trigger`

## Requirements
- R1: After reset, `start_pulse` is 0 and `cfg_bad` reflects only the current configuration inputs (0 for internal trigger mode).
- R2: In internal mode (`cfg_mode` = 0), an accepted `xfer_req` produces `start_pulse` on the next clock edge, without regard to the tearing-effect line.
- R3: A pulse at the vsync active level that lasts at least `cfg_vs_width` cycles is a vsync. In vsync mode (`cfg_mode` = 1) the first vsync after arming raises `start_pulse`, 4 cycles after the pulse's trailing edge (two synchronizer stages, classification, trigger register).
- R4: A pulse at the hsync active level that lasts at least `cfg_hs_width` cycles but fewer than `cfg_vs_width` cycles is an hsync. A pulse is never both, and an hsync never fires vsync mode.
- R5: A pulse shorter than `cfg_hs_width` is ignored. It neither fires a trigger nor advances the line count.
- R6: In line mode (`cfg_mode` = 2), each vsync clears a line count and each later hsync adds one to it. `start_pulse` fires 4 cycles after the trailing edge of the hsync that brings the count to `cfg_line`. A target of 0 fires on the vsync itself.
- R7: A polarity input of 1 makes that pulse kind active high, and 0 makes it active low. A run at the other level is never classified as that kind.
- R8: A request produces at most one start pulse. Requests made while armed or already triggered are ignored. `frame_done` after the trigger returns the block to idle, so that a new request is accepted.
- R9: `cfg_bad` is 1 in any of these cases: mode 3; or, in modes 1 and 2, hsync width below 2, equal hsync and vsync widths, or vsync width below 4 (mode 1) or below 2 (mode 2). While `cfg_bad` is 1, requests are refused and no start pulse fires.
- R10: `start_pulse` is high for exactly one cycle.
- R11: The 11-bit target line reaches its maximum, 2047. With that target, the 2047th hsync after a vsync fires, and none before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | 0 internal, 1 vsync, 2 line, 3 invalid |
| cfg_hs_width | input | WIDTH_W | Minimum hsync pulse length, in cycles |
| cfg_vs_width | input | WIDTH_W | Minimum vsync pulse length, in cycles |
| cfg_hs_pol | input | 1 | 1 = hsync active high, 0 = active low |
| cfg_vs_pol | input | 1 | 1 = vsync active high, 0 = active low |
| cfg_line | input | LINE_W | Target line number for line mode |
| xfer_req | input | 1 | One-cycle request to arm a transfer |
| frame_done | input | 1 | One-cycle notice that the triggered transfer ended |
| te_in | input | 1 | Asynchronous tearing-effect line from the panel |
| start_pulse | output | 1 | One-cycle frame start towards the pixel packer |
| cfg_bad | output | 1 | Current configuration is invalid |

## Verification
The start pulse is due at two distinct times:

- **Internal mode:** one cycle after the request.
- **Tearing-effect modes:** exactly four cycles after the trailing edge of the deciding pulse on `te_in`.

The bench drives inputs on falling edges and keeps a cycle count that advances on rising edges. A monitor stamps each start pulse with that count. Each check compares the stamp against the trailing-edge stamp plus four, or against the request stamp plus one. Every pulse is followed by at least six idle cycles before counts are compared, so a late or missing trigger is seen as a mismatch, not as a race. `cfg_bad` is combinational and is read one falling edge after the configuration changes.

// File: rtl/te_sync_pkg.sv
package te_sync_pkg;

  typedef enum logic [1:0] {
    TRIG_INTERNAL = 2'd0,
    TRIG_VSYNC    = 2'd1,
    TRIG_LINE     = 2'd2,
    TRIG_RSVD     = 2'd3
  } trig_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_FIRED = 2'd2
  } arm_state_e;

  localparam int unsigned HS_FLOOR       = 2;
  localparam int unsigned VS_FLOOR_VSYNC = 4;
  localparam int unsigned VS_FLOOR_LINE  = 2;

endpackage

// File: rtl/te_input_sync.sv
module te_input_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/te_pulse_classifier.sv
module te_pulse_classifier #(
  parameter int unsigned WIDTH_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lvl_in,
  input  logic [WIDTH_W-1:0] hs_width,
  input  logic [WIDTH_W-1:0] vs_width,
  input  logic               hs_act,
  input  logic               vs_act,
  output logic               v_evt,
  output logic               h_evt
);
  localparam logic [WIDTH_W-1:0] RUN_MAX = {WIDTH_W{1'b1}};

  logic               lvl_q;
  logic               first_q;
  logic [WIDTH_W-1:0] run_q;
  logic               run_end;
  logic               is_v;
  logic               is_h;

  assign run_end = (lvl_in != lvl_q);

  // A finished run is judged by its level and its saturated length.
  always_comb begin
    is_v = (lvl_q == vs_act) && (run_q >= vs_width);
    is_h = !is_v && (lvl_q == hs_act) && (run_q >= hs_width);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= 1'b0;
      first_q <= 1'b1;
      run_q   <= '0;
      v_evt   <= 1'b0;
      h_evt   <= 1'b0;
    end else begin
      // The run in progress at reset has unknown length and is never judged.
      v_evt <= run_end && !first_q && is_v;
      h_evt <= run_end && !first_q && is_h;
      if (run_end) begin
        lvl_q   <= lvl_in;
        run_q   <= {{(WIDTH_W-1){1'b0}}, 1'b1};
        first_q <= 1'b0;
      end else if (run_q != RUN_MAX) begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/te_line_tracker.sv
module te_line_tracker #(
  parameter int unsigned LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              v_evt,
  input  logic              h_evt,
  input  logic [LINE_W-1:0] target,
  output logic              line_hit
);
  localparam logic [LINE_W-1:0] CNT_MAX = {LINE_W{1'b1}};

  logic              frame_ok_q;
  logic [LINE_W-1:0] cnt_q;
  logic [LINE_W:0]   cnt_next;

  assign cnt_next = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    line_hit = 1'b0;
    if (v_evt && (target == '0))
      line_hit = 1'b1;
    else if (h_evt && frame_ok_q && (cnt_next == {1'b0, target}))
      line_hit = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_ok_q <= 1'b0;
      cnt_q      <= '0;
    end else if (v_evt) begin
      frame_ok_q <= 1'b1;
      cnt_q      <= '0;
    end else if (h_evt && frame_ok_q && (cnt_q != CNT_MAX)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/te_trigger_fsm.sv
module te_trigger_fsm
  import te_sync_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       cfg_bad,
  input  logic       req,
  input  logic       frame_done,
  input  logic       v_evt,
  input  logic       line_hit,
  output logic       start,
  output arm_state_e state
);
  arm_state_e state_q;
  logic       fire_now;

  always_comb begin
    fire_now = 1'b0;
    if (!cfg_bad) begin
      unique case (mode)
        TRIG_INTERNAL: fire_now = 1'b1;
        TRIG_VSYNC:    fire_now = v_evt;
        TRIG_LINE:     fire_now = line_hit;
        default:       fire_now = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      start   <= 1'b0;
    end else begin
      start <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req && !cfg_bad) begin
            if (mode == TRIG_INTERNAL) begin
              start   <= 1'b1;
              state_q <= ST_FIRED;
            end else begin
              state_q <= ST_ARMED;
            end
          end
        end
        ST_ARMED: begin
          if (fire_now) begin
            start   <= 1'b1;
            state_q <= ST_FIRED;
          end
        end
        ST_FIRED: begin
          if (frame_done) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state = state_q;
endmodule

// File: rtl/te_sync_trigger.sv
module te_sync_trigger
  import te_sync_pkg::*;
#(
  parameter int unsigned WIDTH_W     = 6,
  parameter int unsigned LINE_W      = 11,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         cfg_mode,
  input  logic [WIDTH_W-1:0] cfg_hs_width,
  input  logic [WIDTH_W-1:0] cfg_vs_width,
  input  logic               cfg_hs_pol,
  input  logic               cfg_vs_pol,
  input  logic [LINE_W-1:0]  cfg_line,
  input  logic               xfer_req,
  input  logic               frame_done,
  input  logic               te_in,
  output logic               start_pulse,
  output logic               cfg_bad
);
  localparam logic [WIDTH_W-1:0] HS_MIN_W   = WIDTH_W'(HS_FLOOR);
  localparam logic [WIDTH_W-1:0] VS_MIN_V_W = WIDTH_W'(VS_FLOOR_VSYNC);
  localparam logic [WIDTH_W-1:0] VS_MIN_L_W = WIDTH_W'(VS_FLOOR_LINE);

  logic               te_s;
  logic               v_evt;
  logic               h_evt;
  logic               line_hit;
  arm_state_e         fsm_state;
  logic [WIDTH_W-1:0] vs_floor;

  // Configuration validity: widths must separate the two pulse kinds.
  always_comb begin
    vs_floor = (cfg_mode == TRIG_VSYNC) ? VS_MIN_V_W : VS_MIN_L_W;
    if (cfg_mode == TRIG_RSVD)
      cfg_bad = 1'b1;
    else if (cfg_mode == TRIG_INTERNAL)
      cfg_bad = 1'b0;
    else
      cfg_bad = (cfg_hs_width < HS_MIN_W) || (cfg_vs_width < vs_floor) ||
                (cfg_hs_width == cfg_vs_width);
  end

  te_input_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (te_in),
    .q     (te_s)
  );

  te_pulse_classifier #(.WIDTH_W(WIDTH_W)) u_class (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl_in   (te_s),
    .hs_width (cfg_hs_width),
    .vs_width (cfg_vs_width),
    .hs_act   (cfg_hs_pol),
    .vs_act   (cfg_vs_pol),
    .v_evt    (v_evt),
    .h_evt    (h_evt)
  );

  te_line_tracker #(.LINE_W(LINE_W)) u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .v_evt    (v_evt),
    .h_evt    (h_evt),
    .target   (cfg_line),
    .line_hit (line_hit)
  );

  te_trigger_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (cfg_mode),
    .cfg_bad    (cfg_bad),
    .req        (xfer_req),
    .frame_done (frame_done),
    .v_evt      (v_evt),
    .line_hit   (line_hit),
    .start      (start_pulse),
    .state      (fsm_state)
  );
endmodule

// File: rtl/te_sync_trigger_chk.sv
module te_sync_trigger_chk
  import te_sync_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       start_pulse,
  input logic       frame_done,
  input logic       xfer_req,
  input logic       cfg_bad,
  input logic [1:0] cfg_mode,
  input logic       v_evt,
  input logic       h_evt,
  input arm_state_e state
);
  logic fired_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           fired_q <= 1'b0;
    else if (frame_done)  fired_q <= 1'b0;
    else if (start_pulse) fired_q <= 1'b1;
  end

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse); // R10

  AST_ONE_PER_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> !fired_q); // R8

  AST_BAD_CFG_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> !$past(cfg_bad)); // R9

  AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({v_evt, h_evt})); // R4

  AST_INTERNAL_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && xfer_req && cfg_mode == 2'd0 && !cfg_bad) |=> start_pulse); // R2

  AST_VSYNC_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARMED && cfg_mode == 2'd1 && !cfg_bad && v_evt) |=> start_pulse); // R3
endmodule

bind te_sync_trigger te_sync_trigger_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_pulse (start_pulse),
  .frame_done  (frame_done),
  .xfer_req    (xfer_req),
  .cfg_bad     (cfg_bad),
  .cfg_mode    (cfg_mode),
  .v_evt       (v_evt),
  .h_evt       (h_evt),
  .state       (fsm_state)
);

// File: tb/tb_te_sync_trigger.sv
`timescale 1ns/1ps
module tb_te_sync_trigger;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic [5:0]  cfg_hs_width = 6'd3;
  logic [5:0]  cfg_vs_width = 6'd8;
  logic        cfg_hs_pol = 1'b1;
  logic        cfg_vs_pol = 1'b1;
  logic [10:0] cfg_line = '0;
  logic        xfer_req = 1'b0;
  logic        frame_done = 1'b0;
  logic        te_in = 1'b0;
  logic        start_pulse;
  logic        cfg_bad;

  logic idle_lvl = 1'b0;
  int   cyc = 0;
  int   n_start = 0;
  int   last_start = -1;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   finished = 1'b0;

  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (start_pulse) begin
      n_start++;
      last_start = cyc;
    end
  end

  te_sync_trigger dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_hs_width(cfg_hs_width),
    .cfg_vs_width(cfg_vs_width), .cfg_hs_pol(cfg_hs_pol), .cfg_vs_pol(cfg_vs_pol),
    .cfg_line(cfg_line), .xfer_req(xfer_req), .frame_done(frame_done),
    .te_in(te_in), .start_pulse(start_pulse), .cfg_bad(cfg_bad)
  );

  task automatic check_eq(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic set_cfg(input logic [1:0] m, input int hs, input int vs,
                         input bit hp, input bit vp, input int ln);
    cfg_mode = m; cfg_hs_width = 6'(hs); cfg_vs_width = 6'(vs);
    cfg_hs_pol = hp; cfg_vs_pol = vp; cfg_line = 11'(ln);
    idle_lvl = ~vp;
    te_in = idle_lvl;
    repeat (8) @(negedge clk);
  endtask

  task automatic arm();
    xfer_req = 1'b1;
    @(negedge clk);
    xfer_req = 1'b0;
  endtask

  task automatic finish_frame();
    frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse(input int w, input int gap, output int tf);
    te_in = ~idle_lvl;
    repeat (w) @(negedge clk);
    te_in = idle_lvl;
    tf = cyc;
    repeat (gap) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_eq("R1 start low in reset", int'(start_pulse), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_eq("R1 start low after reset", int'(start_pulse), 0);
    check_eq("R1 cfg_bad internal", int'(cfg_bad), 0);
  endtask

  task automatic t_internal();
    int base;
    set_cfg(2'd0, 3, 8, 1, 1, 0);
    xfer_req = 1'b1;
    @(negedge clk);
    xfer_req = 1'b0;
    check_eq("R2 start one cycle after request", int'(start_pulse), 1);
    @(negedge clk);
    check_eq("R10 start single cycle", int'(start_pulse), 0);
    base = n_start;
    arm();
    repeat (5) @(negedge clk);
    check_eq("R8 request ignored while fired", n_start, base);
    finish_frame();
    arm();
    check_eq("R8 rearm after frame done", int'(start_pulse), 1);
    finish_frame();
  endtask

  task automatic t_vsync_mode();
    int base, tf;
    set_cfg(2'd1, 3, 8, 1, 1, 0);
    base = n_start;
    arm();
    pulse(4, 8, tf);
    check_eq("R4 hsync does not fire vsync mode", n_start, base);
    pulse(1, 8, tf);
    check_eq("R5 short pulse ignored", n_start, base);
    pulse(7, 8, tf);
    check_eq("R4 one below vsync width is hsync", n_start, base);
    pulse(8, 8, tf);
    check_eq("R3 vsync fires once", n_start, base + 1);
    check_eq("R3 vsync trigger latency", last_start, tf + LAT);
    pulse(8, 8, tf);
    check_eq("R8 second vsync no trigger", n_start, base + 1);
    finish_frame();
  endtask

  task automatic t_line_mode();
    int base, tf;
    set_cfg(2'd2, 3, 8, 1, 1, 3);
    base = n_start;
    arm();
    pulse(8, 8, tf);
    pulse(3, 6, tf);
    pulse(3, 6, tf);
    pulse(2, 6, tf);
    check_eq("R5 short pulse not counted as line", n_start, base);
    pulse(3, 6, tf);
    check_eq("R6 fires on target line", n_start, base + 1);
    check_eq("R6 line trigger latency", last_start, tf + LAT);
    finish_frame();
    set_cfg(2'd2, 3, 8, 1, 1, 0);
    base = n_start;
    arm();
    pulse(8, 8, tf);
    check_eq("R6 target zero fires on vsync", n_start, base + 1);
    check_eq("R6 target zero latency", last_start, tf + LAT);
    finish_frame();
  endtask

  task automatic t_polarity();
    int base, tf;
    set_cfg(2'd1, 3, 8, 0, 0, 0);
    base = n_start;
    arm();
    pulse(2, 20, tf);
    pulse(2, 8, tf);
    check_eq("R7 long inactive-level run ignored", n_start, base);
    pulse(8, 8, tf);
    check_eq("R7 active-low vsync fires", n_start, base + 1);
    check_eq("R7 active-low latency", last_start, tf + LAT);
    finish_frame();
    set_cfg(2'd0, 3, 8, 1, 1, 0);
  endtask

  task automatic t_cfg_bad();
    int base, tf;
    set_cfg(2'd1, 3, 3, 1, 1, 0);
    check_eq("R9 equal widths invalid", int'(cfg_bad), 1);
    set_cfg(2'd1, 2, 3, 1, 1, 0);
    check_eq("R9 vsync below 4 invalid in mode 1", int'(cfg_bad), 1);
    set_cfg(2'd2, 2, 3, 1, 1, 0);
    check_eq("R9 vsync 3 valid in mode 2", int'(cfg_bad), 0);
    set_cfg(2'd2, 2, 1, 1, 1, 0);
    check_eq("R9 vsync below 2 invalid in mode 2", int'(cfg_bad), 1);
    set_cfg(2'd1, 1, 8, 1, 1, 0);
    check_eq("R9 hsync below 2 invalid", int'(cfg_bad), 1);
    set_cfg(2'd3, 3, 8, 1, 1, 0);
    check_eq("R9 mode 3 invalid", int'(cfg_bad), 1);
    set_cfg(2'd0, 1, 1, 1, 1, 0);
    check_eq("R9 internal mode ignores widths", int'(cfg_bad), 0);
    set_cfg(2'd1, 2, 3, 1, 1, 0);
    base = n_start;
    arm();
    pulse(8, 8, tf);
    check_eq("R9 no trigger with bad config", n_start, base);
    cfg_vs_width = 6'd8;
    @(negedge clk);
    pulse(8, 8, tf);
    check_eq("R9 refused request stays refused", n_start, base);
  endtask

  task automatic t_line_max();
    int base, tf;
    set_cfg(2'd2, 2, 5, 1, 1, 2047);
    base = n_start;
    arm();
    pulse(5, 4, tf);
    for (int i = 0; i < 2046; i++) pulse(2, 3, tf);
    repeat (6) @(negedge clk);
    check_eq("R11 no trigger before line 2047", n_start, base);
    pulse(2, 6, tf);
    check_eq("R11 fires on line 2047", n_start, base + 1);
    check_eq("R11 line 2047 latency", last_start, tf + LAT);
    finish_frame();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_internal();
    t_vsync_mode();
    t_line_mode();
    t_polarity();
    t_cfg_bad();
    t_line_max();
    summary();
  end
endmodule